// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external serial master read and write a small register file inside the chip over a four-wire synchronous link. The block runs on the chip's system clock. It passes the serial clock, the data-in line and the active-low select through two-flop synchronizers, and finds the serial clock edges by oversampling. Only clock mode 0 is supported: the clock idles low, the slave samples on the rising edge and changes its output on the falling edge.

Each transaction opens when select goes low. The first byte is a command that carries a register address and a direction bit. Data bytes follow, and each completed data byte advances the address. A configuration bit in register 0 selects the read path. In full-duplex mode read data leaves on the separate MISO pin. In half-duplex mode the slave takes over the shared MOSI wire once the command byte ends, and drives read data on it through an output enable. Raising select ends the transaction and throws away any partial byte.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, the port is in full-duplex mode, and both `miso_oe_o` and `mosi_oe_o` are low.
- R2: Bits travel MSB first and are sampled on the rising serial clock edge. In the command byte, bits [7:3] hold the register address and bit 1 holds the direction (1 = write). Bits 2 and 0 have no effect on the operation.
- R3: In a write transaction, each complete data byte after the command is stored in the addressed register and appears on `regs_o` at bit offset 8*address. Registers change only while the synchronized select is low.
- R4: The register address advances by one after each complete data byte in a transaction, and wraps from 31 to 0.
- R5: In a full-duplex read, each data byte shows the addressed register on `miso_o`, MSB first. A new bit is set up after each falling serial clock edge.
- R6: In full-duplex mode, `miso_o` shifts out the `status_i` byte, MSB first, while the command byte is being received.
- R7: When select rises, any partial byte is discarded without a write. The next transaction begins again with a command byte.
- R8: `miso_oe_o` is high only while `cs_ni` is low and the port is in full-duplex mode, and it follows `cs_ni` combinationally.
- R9: Bit 0 of register 0 set to 1 selects half-duplex mode. In that mode, a read raises `mosi_oe_o` after the falling edge that ends the command byte, and drives the register data MSB first on `mosi_o`. `mosi_oe_o` stays low in full-duplex mode, during the command byte and in write transactions.
- R10: `mosi_oe_o` drops in the same instant that `cs_ni` rises, with no system clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Active-low transaction select |
| mosi_i | input | 1 | Data-in pin, the receive side of the shared wire |
| mosi_o | output | 1 | Half-duplex read data driven onto the data-in wire |
| mosi_oe_o | output | 1 | Output enable for `mosi_o` |
| miso_o | output | 1 | Full-duplex serial output |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| status_i | input | 8 | Status byte sent during the command byte |
| regs_o | output | NREGS*8 | Flat view of the register file, register n at bits [8n+7:8n] |

## Verification
The hardest case to reach is the hand-over on the shared data wire. The slave must take the wire only after the eighth falling edge of a read command in half-duplex mode, and let it go the instant select rises. The bench models the wire as a resolved mux: the slave's enable picks its bit and otherwise the master's bit is used. It first switches the mode through an ordinary write to register 0, then runs a read. It samples the enable during the command byte and after the command byte, and samples it again one time step after select rises. A separate sequence raises select in the middle of a byte, both inside a command and inside a data byte, to reach the abort path.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned CNT_W    = $clog2(BYTE_W);
  localparam int unsigned CFG_ADDR = 0;
  localparam int unsigned CFG_HD   = 0;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WR,
    PH_RD
  } phase_e;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_slave_pkg::*;
#(
  parameter int unsigned NREGS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  addr_t                 wr_addr_i,
  input  byte_t                 wr_data_i,
  input  addr_t                 rd_addr_i,
  output byte_t                 rd_data_o,
  output logic                  hd_mode_o,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned SPAN = 1 << ADDR_W;

  byte_t mem_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[r] <= '0;
      else if (wr_en_i && (wr_addr_i == addr_t'(r)))   mem_q[r] <= wr_data_i;
    end
    assign regs_o[r*BYTE_W +: BYTE_W] = mem_q[r];
  end

  // Full address span needs no range check; a short file reads zero above its top
  if (NREGS >= SPAN) begin : g_full
    assign rd_data_o = mem_q[rd_addr_i];
  end else begin : g_part
    assign rd_data_o = (int'(rd_addr_i) < NREGS) ? mem_q[rd_addr_i] : '0;
  end

  assign hd_mode_o = mem_q[CFG_ADDR][CFG_HD];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_slave_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_s_i,
  input  logic  mosi_s_i,
  input  logic  cs_s_i,
  input  byte_t status_i,
  input  byte_t rd_data_i,
  input  logic  hd_mode_i,
  output addr_t rd_addr_o,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output logic  tx_bit_o,
  output logic  hd_drive_o
);
  logic                  sclk_q, cs_q;
  logic [CNT_W-1:0]      bit_cnt_q;
  logic [BYTE_W-2:0]     rx_q;
  byte_t                 tx_q;
  addr_t                 addr_q;
  phase_e                phase_q;
  logic                  hd_drive_q;

  logic  rise, fall, cs_fall, byte_done;
  byte_t rx_byte;

  assign rise      = sclk_s_i & ~sclk_q & ~cs_s_i;
  assign fall      = ~sclk_s_i & sclk_q & ~cs_s_i;
  assign cs_fall   = cs_q & ~cs_s_i;
  assign rx_byte   = {rx_q, mosi_s_i};
  assign byte_done = rise && (bit_cnt_q == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_s_i;
    end
  end

  // Receive side: bit count, command decode, address stepping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      addr_q    <= '0;
      phase_q   <= PH_CMD;
    end else if (cs_s_i) begin
      bit_cnt_q <= '0;  // partial byte dropped
      phase_q   <= PH_CMD;
    end else if (rise) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      rx_q      <= rx_byte[BYTE_W-2:0];
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            addr_q  <= rx_byte[BYTE_W-1 -: ADDR_W];
            phase_q <= rx_byte[1] ? PH_WR : PH_RD;
          end
          default: addr_q <= addr_q + 1'b1;
        endcase
      end
    end
  end

  // Transmit side: load at byte boundary, shift on falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      hd_drive_q <= 1'b0;
    end else if (cs_s_i) begin
      hd_drive_q <= 1'b0;
    end else if (cs_fall) begin
      tx_q <= status_i;
    end else if (fall) begin
      if (bit_cnt_q == '0) begin
        tx_q <= rd_data_i;
        if (phase_q == PH_RD && hd_mode_i) hd_drive_q <= 1'b1;
      end else begin
        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign wr_en_o    = byte_done && (phase_q == PH_WR);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = rx_byte;
  assign rd_addr_o  = addr_q;
  assign tx_bit_o   = tx_q[BYTE_W-1];
  assign hd_drive_o = hd_drive_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_slave_pkg::*;
#(
  parameter int unsigned NREGS = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sclk_i,
  input  logic                    cs_ni,
  input  logic                    mosi_i,
  output logic                    mosi_o,
  output logic                    mosi_oe_o,
  output logic                    miso_o,
  output logic                    miso_oe_o,
  input  logic [BYTE_W-1:0]       status_i,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  logic  cs_s, sclk_s, mosi_s;
  logic  wr_en, hd_mode, hd_drive, tx_bit;
  addr_t wr_addr, rd_addr;
  byte_t wr_data, rd_data;

  spi_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, mosi_i}),
    .q_o    ({cs_s, sclk_s, mosi_s})
  );

  spi_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .mosi_s_i   (mosi_s),
    .cs_s_i     (cs_s),
    .status_i   (status_i),
    .rd_data_i  (rd_data),
    .hd_mode_i  (hd_mode),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .tx_bit_o   (tx_bit),
    .hd_drive_o (hd_drive)
  );

  spi_regfile #(.NREGS(NREGS)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .hd_mode_o (hd_mode),
    .regs_o    (regs_o)
  );

  // Enables gated by the raw select so release needs no clock edge
  assign miso_o    = tx_bit;
  assign miso_oe_o = ~cs_ni & ~hd_mode;
  assign mosi_o    = tx_bit;
  assign mosi_oe_o = ~cs_ni & hd_drive;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned NREGS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 cs_s,
  input logic                 hd_mode,
  input logic                 miso_oe_o,
  input logic                 mosi_oe_o,
  input logic [NREGS*8-1:0]   regs_o
);
  // R3: no register update outside a synchronized transaction
  a_r3_regs_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(regs_o));

  // R8: MISO released while select is high
  a_r8_miso_hiz_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_oe_o);

  // R9: never both pins driven at once
  a_r9_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mosi_oe_o && miso_oe_o));

  // R9: shared wire only taken in half-duplex mode
  a_r9_hd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> hd_mode);

  // R10: shared wire released while select is high
  a_r10_mosi_hiz_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !mosi_oe_o);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NREGS(NREGS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .cs_s      (cs_s),
  .hd_mode   (hd_mode),
  .miso_oe_o (miso_oe_o),
  .mosi_oe_o (mosi_oe_o),
  .regs_o    (regs_o)
);

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;
  localparam int NREGS = 32;
  localparam int HP    = 8;  // system clocks per serial half period
  localparam int NV    = 6;
  // {addr, bit2, bit0, data}
  localparam logic [14:0] VECS [NV] = '{
    {5'd3,  2'b00, 8'hA5},
    {5'd5,  2'b01, 8'h3C},
    {5'd6,  2'b10, 8'hC3},
    {5'd12, 2'b11, 8'h7E},
    {5'd21, 2'b00, 8'h81},
    {5'd31, 2'b01, 8'h5B}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi_m = 1'b0;
  logic mosi_o, mosi_oe, miso_o, miso_oe, mosi_line;
  logic [7:0] status = 8'h5A;
  logic [NREGS*8-1:0] regs;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign mosi_line = mosi_oe ? mosi_o : mosi_m;

  spi_reg_slave #(.NREGS(NREGS)) i_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi_line),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .status_i(status), .regs_o(regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel;
    @(negedge clk); cs_n = 1'b0; wait_clk(6);
  endtask

  task automatic desel;
    wait_clk(HP); cs_n = 1'b1; wait_clk(2 * HP);
  endtask

  // Shifts nbits of tx (MSB first); samples miso or the shared wire before each rise
  task automatic xfer(input logic [7:0] tx, input int nbits, input bit from_wire,
                      output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_m = tx[i];
      wait_clk(HP);
      rx[i] = from_wire ? mosi_line : miso_o;
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic wr1(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] rx;
    sel;
    xfer({a, 3'b010}, 8, 1'b0, rx);
    xfer(d, 8, 1'b0, rx);
    desel;
  endtask

  task automatic rd1(input logic [4:0] a, output logic [7:0] d);
    logic [7:0] rx;
    sel;
    xfer({a, 3'b000}, 8, 1'b0, rx);
    xfer(8'h00, 8, 1'b0, d);
    desel;
  endtask

  initial begin
    wait_clk(150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx, d;
    wait_clk(3);
    // R1 reset state
    chk("R1 regs", 32'(regs == '0), 32'd1);
    chk("R1 miso_oe", 32'(miso_oe), 32'd0);
    chk("R1 mosi_oe", 32'(mosi_oe), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 after release", 32'(regs == '0), 32'd1);

    // R2/R3/R5 table: write with junk in bits 2 and 0, then read back
    for (int v = 0; v < NV; v++) begin
      logic [4:0] a;
      logic [1:0] j;
      logic [7:0] dv;
      {a, j, dv} = VECS[v];
      sel;
      xfer({a, j[1], 1'b1, j[0]}, 8, 1'b0, rx);
      xfer(dv, 8, 1'b0, rx);
      desel;
      chk("R3 R2 write", 32'(regs[a*8 +: 8]), 32'(dv));
      rd1(a, d);
      chk("R5 read", 32'(d), 32'(dv));
    end

    // R6 status during command; R8 enable while selected
    sel;
    chk("R8 miso_oe selected", 32'(miso_oe), 32'd1);
    xfer(8'b00011_000, 8, 1'b0, rx);
    chk("R6 status byte", 32'(rx), 32'h5A);
    xfer(8'h00, 8, 1'b0, rx);
    chk("R5 read reg3", 32'(rx), 32'hA5);
    wait_clk(HP);
    cs_n = 1'b1;
    #1;
    chk("R8 miso_oe released", 32'(miso_oe), 32'd0);
    wait_clk(2 * HP);

    // R4 burst write across the wrap 30,31,0
    sel;
    xfer({5'd30, 3'b010}, 8, 1'b0, rx);
    xfer(8'h11, 8, 1'b0, rx);
    xfer(8'h22, 8, 1'b0, rx);
    xfer(8'h32, 8, 1'b0, rx);
    desel;
    chk("R4 reg30", 32'(regs[30*8 +: 8]), 32'h11);
    chk("R4 reg31", 32'(regs[31*8 +: 8]), 32'h22);
    chk("R4 wrap reg0", 32'(regs[0 +: 8]), 32'h32);
    // R4 burst read
    sel;
    xfer({5'd30, 3'b000}, 8, 1'b0, rx);
    xfer(8'h00, 8, 1'b0, rx); chk("R4 burst rd30", 32'(rx), 32'h11);
    xfer(8'h00, 8, 1'b0, rx); chk("R4 burst rd31", 32'(rx), 32'h22);
    xfer(8'h00, 8, 1'b0, rx); chk("R4 burst rd0", 32'(rx), 32'h32);
    desel;

    // R7 abort inside a data byte, then inside a command byte
    sel;
    xfer({5'd7, 3'b010}, 8, 1'b0, rx);
    xfer(8'hFF, 4, 1'b0, rx);
    desel;
    chk("R7 partial data dropped", 32'(regs[7*8 +: 8]), 32'h00);
    sel;
    xfer({5'd7, 3'b010}, 5, 1'b0, rx);
    desel;
    wr1(5'd7, 8'h3C);
    chk("R7 fresh command", 32'(regs[7*8 +: 8]), 32'h3C);

    // R9 half-duplex read on the shared wire
    wr1(5'd0, 8'h01);
    sel;
    chk("R8 miso_oe in half duplex", 32'(miso_oe), 32'd0);
    xfer({5'd5, 3'b000}, 7, 1'b0, rx);
    chk("R9 no drive in command", 32'(mosi_oe), 32'd0);
    xfer({5'd5, 3'b000} << 7, 1, 1'b0, rx);
    wait_clk(6);
    chk("R9 drive after command", 32'(mosi_oe), 32'd1);
    xfer(8'h00, 8, 1'b1, rx);
    chk("R9 hd data reg5", 32'(rx), 32'h3C);
    xfer(8'h00, 8, 1'b1, rx);
    chk("R9 hd data reg6", 32'(rx), 32'hC3);
    wait_clk(HP);
    cs_n = 1'b1;
    #1;
    chk("R10 release at select rise", 32'(mosi_oe), 32'd0);
    wait_clk(2 * HP);

    // R9 write in half-duplex does not drive; return to full duplex
    sel;
    xfer({5'd0, 3'b010}, 8, 1'b0, rx);
    wait_clk(6);
    chk("R9 no drive on write", 32'(mosi_oe), 32'd0);
    xfer(8'h00, 8, 1'b0, rx);
    desel;
    rd1(5'd21, d);
    chk("R9 back to full duplex", 32'(d), 32'h81);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule